// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a virtual page through an in-memory hashed page table once a faster block-translation lookup has missed. A requester presents an effective address, the segment descriptor picked by the top four address bits, the table base-and-size register, the privilege level and a write flag, then pulses `start`. The walker derives a group address and a 32-bit comparison tag, reads the group's entries one at a time through a plain request/ready read port, and stops at the first matching entry. If none of the eight entries match, it repeats the search in the alternate group given by the complemented hash.

On a match it fetches the entry's second word and forms the real address. It decodes read and write rights from the two-bit protection field and a key bit taken from the segment descriptor. It then updates the entry's referenced and changed flags in memory with single-byte writes, so the neighbouring bytes of the word are never rewritten. Completion is a one-cycle `done` pulse with a two-bit status: hit, no entry, or protection fault.

Top module: `hpt_walker`

## Requirements
- R1: The primary group address is the table register's bits 31:16 placed in bits 31:16, ORed with ((segment bits 23:0 XOR effective-address bits 27:12) shifted left by 6) ANDed with ((table bits 8:0 shifted left by 16) OR 0xFFC0). The first read of a walk goes to this address.
- R2: The alternate search uses the bitwise complement of the shifted hash, with the same mask and base. It starts only after all eight primary entries have been read without a match.
- R3: The comparison tag is {1, segment bits 23:0, alternate-search flag, effective-address bits 27:22}. An entry matches only when its first word (at the entry address) equals this tag exactly. In particular, a primary-form tag never matches during the alternate search, and the reverse also holds.
- R4: Entry k of a group sits at the group address plus 8*k, and its second word sits 4 bytes after the first. Entries are read in order 0 to 7, one read per entry, and the first match stops the scan before any later entry is read.
- R5: On a match, the reported real address is bits 31:12 of the second word joined with effective-address bits 11:0.
- R6: The key is segment bit 29 in user mode and segment bit 30 in supervisor mode. The effective protection value is {key, pp}, where pp is bits 1:0 of the second word. Write is allowed for values 0, 1, 2 and 6. Read is allowed for every value except 4. Execute is always reported as allowed on a match.
- R7: If the access is readable and bit 8 of the second word is clear, the walker issues one byte write with byte enable 4'b0010, which covers data bits 15:8 (byte offset 2 of the big-endian word), and sets bit 8.
- R8: If the access is a write, writing is allowed and bit 7 is clear, the walker issues one byte write with byte enable 4'b0001, which covers data bits 7:0 (byte offset 3), and sets bit 7. Otherwise it issues no such write. This write comes after the referenced-flag write.
- R9: Status codes are 1 for hit, 2 for no entry and 3 for protection fault. A match that denies the requested access reports 3. Sixteen reads without a match report 2.
- R10: A request holds its address, data and enables unchanged until `mem_ready` is high. `done` lasts exactly one cycle. A `start` received during a walk is ignored.
- R11: Read data is taken exactly RD_LAT cycles after the clock edge at which the read was accepted. Reads always use all four byte enables and a word-aligned address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk with the current inputs (taken only when idle) |
| ea | input | 32 | Effective address |
| seg | input | 32 | Segment descriptor for the address |
| tbl | input | 32 | Table base (bits 31:16) and size mask (bits 8:0) |
| user_mode | input | 1 | 1 for user privilege, 0 for supervisor |
| is_write | input | 1 | Access is a store |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_be | output | 4 | Byte enables, bit i covers data bits 8i+7:8i |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid RD_LAT cycles after acceptance |
| done | output | 1 | One-cycle walk completion pulse |
| status | output | 2 | 1 hit, 2 no entry, 3 protection fault |
| real_addr | output | 32 | Translated address on a match |
| may_read | output | 1 | Read right of the matched entry |
| may_write | output | 1 | Write right of the matched entry |
| may_exec | output | 1 | Execute right of the matched entry |

## Verification
The embedded properties assume a memory that returns read data exactly RD_LAT cycles after acceptance and does not change a word while the walker is fetching it. They also assume that `start` is only meaningful while no walk is in flight. The bench's memory model is a fixed-depth data pipe that matches the latency parameter. Its ready line is either always high or toggles every other cycle, so every request is eventually taken, and a second `start` is pulsed mid-walk only to confirm that it has no effect.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_RD_TAG = 3'd1,
        S_WT_TAG = 3'd2,
        S_RD_PTE = 3'd3,
        S_WT_PTE = 3'd4,
        S_WR_REF = 3'd5,
        S_WR_CHG = 3'd6
    } walk_state_e;

    typedef enum logic [1:0] {
        WS_NONE  = 2'd0,
        WS_HIT   = 2'd1,
        WS_NOENT = 2'd2,
        WS_PROT  = 2'd3
    } walk_status_e;

    localparam logic [3:0] BE_WORD = 4'b1111;
    localparam logic [3:0] BE_REF  = 4'b0010;
    localparam logic [3:0] BE_CHG  = 4'b0001;

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
    parameter int unsigned ENTRIES = 8
) (
    input  logic [31:0] ea,
    input  logic [31:0] seg,
    input  logic [31:0] tbl,
    input  logic        alt,
    output logic [31:0] grp_addr,
    output logic [31:0] tag
);
    // Group alignment follows from the group size: entries of 8 bytes each.
    localparam int unsigned SHIFT    = $clog2(ENTRIES) + 3;
    localparam logic [31:0] LOW_KEEP = ~((32'd1 << SHIFT) - 32'd1);

    logic [23:0] vsid;
    logic [15:0] page;
    logic [31:0] h_pri;
    logic [31:0] h_sel;
    logic [31:0] mask;

    always_comb begin
        vsid     = seg[23:0];
        page     = ea[27:12];
        h_pri    = {8'h00, vsid ^ {8'h00, page}} << SHIFT;
        h_sel    = alt ? ~h_pri : h_pri;
        mask     = {7'd0, tbl[8:0], 16'hFFFF} & LOW_KEEP;
        grp_addr = {tbl[31:16], 16'h0000} | (h_sel & mask);
        tag      = {1'b1, vsid, alt, ea[27:22]};
    end

endmodule

// File: rtl/hpt_perm.sv
module hpt_perm (
    input  logic [31:0] seg,
    input  logic        user,
    input  logic [1:0]  pp,
    output logic        rd_ok,
    output logic        wr_ok
);
    logic       key;
    logic [2:0] eff;

    always_comb begin
        key = user ? seg[29] : seg[30];
        eff = {key, pp};
        unique case (eff)
            3'd0, 3'd1, 3'd2, 3'd6: wr_ok = 1'b1;
            default:                wr_ok = 1'b0;
        endcase
        rd_ok = (eff != 3'd4);
    end

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned RD_LAT  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] ea,
    input  logic [31:0] seg,
    input  logic [31:0] tbl,
    input  logic        user_mode,
    input  logic        is_write,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic [1:0]  status,
    output logic [31:0] real_addr,
    output logic        may_read,
    output logic        may_write,
    output logic        may_exec
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);
    localparam int unsigned LAT_W = $clog2(RD_LAT + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);
    localparam logic [LAT_W-1:0] LAT_END  = LAT_W'(RD_LAT);

    typedef struct packed {
        walk_state_e  fsm;
        logic [IDX_W-1:0] idx;
        logic         alt;
        logic [LAT_W-1:0] lat;
        logic [31:0]  ea;
        logic [31:0]  seg;
        logic [31:0]  tbl;
        logic         user;
        logic         wr;
        logic [31:0]  pte1;
        logic         rd_ok;
        logic         wr_ok;
        logic         done;
        walk_status_e o_status;
        logic [31:0]  o_raddr;
        logic         o_rd;
        logic         o_wr;
        logic         o_x;
    } regs_t;

    regs_t r_d, r_q;

    logic [31:0] grp_addr;
    logic [31:0] tag;
    logic [31:0] entry_addr;
    logic        pm_rd;
    logic        pm_wr;

    hpt_hash #(.ENTRIES(ENTRIES)) i_hash (
        .ea       (r_q.ea),
        .seg      (r_q.seg),
        .tbl      (r_q.tbl),
        .alt      (r_q.alt),
        .grp_addr (grp_addr),
        .tag      (tag)
    );

    hpt_perm i_perm (
        .seg   (r_q.seg),
        .user  (r_q.user),
        .pp    (mem_rdata[1:0]),
        .rd_ok (pm_rd),
        .wr_ok (pm_wr)
    );

    assign entry_addr = grp_addr + 32'({r_q.idx, 3'b000});

    function automatic regs_t wrap_up(regs_t r);
        regs_t o;
        o          = r;
        o.fsm      = S_IDLE;
        o.done     = 1'b1;
        o.o_status = (r.rd_ok && (!r.wr || r.wr_ok)) ? WS_HIT : WS_PROT;
        o.o_raddr  = {r.pte1[31:12], r.ea[11:0]};
        o.o_rd     = r.rd_ok;
        o.o_wr     = r.wr_ok;
        o.o_x      = 1'b1;
        return o;
    endfunction

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_be    = BE_WORD;
        mem_addr  = entry_addr;
        mem_wdata = '0;
        unique case (r_q.fsm)
            S_IDLE: begin
                if (start) begin
                    r_d.fsm  = S_RD_TAG;
                    r_d.ea   = ea;
                    r_d.seg  = seg;
                    r_d.tbl  = tbl;
                    r_d.user = user_mode;
                    r_d.wr   = is_write;
                    r_d.idx  = '0;
                    r_d.alt  = 1'b0;
                end
            end
            S_RD_TAG: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    r_d.fsm = S_WT_TAG;
                    r_d.lat = LAT_W'(1);
                end
            end
            S_WT_TAG: begin
                if (r_q.lat == LAT_END) begin
                    if (mem_rdata == tag) begin
                        r_d.fsm = S_RD_PTE;
                    end else if (r_q.idx != LAST_IDX) begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.fsm = S_RD_TAG;
                    end else if (!r_q.alt) begin
                        r_d.alt = 1'b1;
                        r_d.idx = '0;
                        r_d.fsm = S_RD_TAG;
                    end else begin
                        r_d.fsm      = S_IDLE;
                        r_d.done     = 1'b1;
                        r_d.o_status = WS_NOENT;
                        r_d.o_raddr  = '0;
                        r_d.o_rd     = 1'b0;
                        r_d.o_wr     = 1'b0;
                        r_d.o_x      = 1'b0;
                    end
                end else begin
                    r_d.lat = r_q.lat + 1'b1;
                end
            end
            S_RD_PTE: begin
                mem_req  = 1'b1;
                mem_addr = entry_addr + 32'd4;
                if (mem_ready) begin
                    r_d.fsm = S_WT_PTE;
                    r_d.lat = LAT_W'(1);
                end
            end
            S_WT_PTE: begin
                if (r_q.lat == LAT_END) begin
                    r_d.pte1  = mem_rdata;
                    r_d.rd_ok = pm_rd;
                    r_d.wr_ok = pm_wr;
                    if (pm_rd && !mem_rdata[8]) begin
                        r_d.fsm = S_WR_REF;
                    end else if (r_q.wr && pm_wr && !mem_rdata[7]) begin
                        r_d.fsm = S_WR_CHG;
                    end else begin
                        r_d = wrap_up(r_d);
                    end
                end else begin
                    r_d.lat = r_q.lat + 1'b1;
                end
            end
            S_WR_REF: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = BE_REF;
                mem_addr  = entry_addr + 32'd4;
                mem_wdata = {16'h0000, r_q.pte1[15:9], 1'b1, 8'h00};
                if (mem_ready) begin
                    if (r_q.wr && r_q.wr_ok && !r_q.pte1[7]) begin
                        r_d.fsm = S_WR_CHG;
                    end else begin
                        r_d = wrap_up(r_d);
                    end
                end
            end
            S_WR_CHG: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = BE_CHG;
                mem_addr  = entry_addr + 32'd4;
                mem_wdata = {24'h000000, 1'b1, r_q.pte1[6:0]};
                if (mem_ready) begin
                    r_d = wrap_up(r_d);
                end
            end
            default: r_d.fsm = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done      = r_q.done;
    assign status    = r_q.o_status;
    assign real_addr = r_q.o_raddr;
    assign may_read  = r_q.o_rd;
    assign may_write = r_q.o_wr;
    assign may_exec  = r_q.o_x;

    // R10: a stalled request keeps every field until accepted
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_be) && $stable(mem_wdata));

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: reads are full-word and aligned
    p_read_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> mem_be == BE_WORD && mem_addr[1:0] == 2'b00);

    // R7: flag updates touch one byte lane and set the flag they target
    p_byte_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> $countones(mem_be) == 1 &&
            ((mem_be == BE_REF && mem_wdata[8]) || (mem_be == BE_CHG && mem_wdata[7])));

    // R8: the changed-flag write belongs only to store accesses
    p_chg_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_be == BE_CHG |-> r_q.wr);

    // R9: a finished walk always carries a real status
    p_status_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status != 2'd0);

    // R6: a reported hit grants the rights the access needs
    p_hit_rights_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && status == 2'd1 |-> may_read && may_exec && (!r_q.wr || may_write));

    // R9: a protection fault always lacks a needed right
    p_prot_denied_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && status == 2'd3 |-> !may_read || (r_q.wr && !may_write));

endmodule

// File: tb/test_hpt_walker.sv
`timescale 1ns/1ps
module test_hpt_walker;
    localparam int unsigned RD_LAT = 2;
    localparam int unsigned NSLOT  = 64;
    localparam int unsigned LOGN   = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ea_i = '0, seg_i = '0, tbl_i = '0;
    logic        user_i = 1'b0, wr_i = 1'b0;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        done, may_read, may_write, may_exec;
    logic [1:0]  status;
    logic [31:0] real_addr;

    int errors = 0;
    int checks = 0;
    logic stall_mode = 1'b0;
    logic [31:0] cyc = '0;

    logic [31:0] m_addr [NSLOT];
    logic [31:0] m_data [NSLOT];
    int          m_n = 0;
    logic [31:0] pipe [RD_LAT];

    int          rd_cnt = 0, wr_cnt = 0;
    logic [31:0] rd_log [LOGN];
    logic [31:0] wr_log_a [LOGN];
    logic [31:0] wr_log_d [LOGN];
    logic [3:0]  wr_log_b [LOGN];
    int rd_base, wr_base, rd_n, wr_n;

    hpt_walker #(.ENTRIES(8), .RD_LAT(RD_LAT)) i_hpt_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .ea(ea_i), .seg(seg_i), .tbl(tbl_i),
        .user_mode(user_i), .is_write(wr_i),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .done(done), .status(status), .real_addr(real_addr),
        .may_read(may_read), .may_write(may_write), .may_exec(may_exec)
    );

    always #4 clk = ~clk;

    assign mem_ready = !stall_mode || cyc[0];
    assign mem_rdata = pipe[RD_LAT-1];

    function automatic logic [31:0] mem_get(input logic [31:0] a);
        for (int k = 0; k < m_n; k++) if (m_addr[k] == a) return m_data[k];
        return 32'h0;
    endfunction

    function automatic int mem_slot(input logic [31:0] a);
        for (int k = 0; k < m_n; k++) if (m_addr[k] == a) return k;
        return -1;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        pipe[0] <= (mem_req && mem_ready && !mem_we) ? mem_get(mem_addr) : 32'hDEAD_BEEF;
        for (int k = 1; k < RD_LAT; k++) pipe[k] <= pipe[k-1];
        if (mem_req && mem_ready && !mem_we) begin
            if (rd_cnt < LOGN) rd_log[rd_cnt] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
        if (mem_req && mem_ready && mem_we) begin
            if (wr_cnt < LOGN) begin
                wr_log_a[wr_cnt] <= mem_addr;
                wr_log_d[wr_cnt] <= mem_wdata;
                wr_log_b[wr_cnt] <= mem_be;
            end
            wr_cnt <= wr_cnt + 1;
            if (mem_slot(mem_addr) >= 0)
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) m_data[mem_slot(mem_addr)][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
    end

    // expected values from the requirements
    function automatic logic [31:0] f_grp(input logic [31:0] a, s, t, input logic alt);
        logic [31:0] h;
        h = {8'h00, s[23:0] ^ {8'h00, a[27:12]}} << 6;
        if (alt) h = ~h;
        return {t[31:16], 16'h0} | (h & ({7'd0, t[8:0], 16'h0} | 32'h0000_FFC0));
    endfunction

    function automatic logic [31:0] f_tag(input logic [31:0] a, s, input logic alt);
        return {1'b1, s[23:0], alt, a[27:22]};
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic mem_clear();
        m_n = 0;
    endtask

    task automatic mem_put(input logic [31:0] a, input logic [31:0] d);
        m_addr[m_n] = a;
        m_data[m_n] = d;
        m_n++;
    endtask

    task automatic walk(input logic [31:0] a, s, t, input logic u, w);
        int n;
        @(negedge clk);
        rd_base = rd_cnt; wr_base = wr_cnt;
        ea_i = a; seg_i = s; tbl_i = t; user_i = u; wr_i = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        if (!done) begin
            errors++;
            $display("FAIL R10: walk timeout actual=%0d expected=done", n);
        end
        rd_n = rd_cnt - rd_base;
        wr_n = wr_cnt - wr_base;
    endtask

    task automatic t_reset();
        chk("R10 reset done", 32'(done), 32'd0);
        chk("R10 reset mem_req", 32'(mem_req), 32'd0);
        chk("R9 reset status", 32'(status), 32'd0);
    endtask

    task automatic t_primary_hit();
        logic [31:0] a = 32'h0345_6789, s = 32'h0000_1234, t = 32'h0012_0000;
        logic [31:0] g = f_grp(a, s, t, 1'b0);
        mem_clear();
        mem_put(g, f_tag(a, s, 1'b0));
        mem_put(g + 4, 32'h8765_4002);
        walk(a, s, t, 1'b0, 1'b0);
        chk("R1 first read address", rd_log[rd_base], g);
        chk("R9 hit status", 32'(status), 32'd1);
        chk("R5 real address", real_addr, 32'h8765_4789);
        chk("R6 exec", 32'(may_exec), 32'd1);
        chk("R7 one write for read", 32'(wr_n), 32'd1);
        chk("R7 ref lane", 32'(wr_log_b[wr_base]), 32'h2);
        chk("R7 ref addr", wr_log_a[wr_base], g + 4);
        chk("R7 ref byte", 32'(wr_log_d[wr_base][15:8]), 32'h41);
        chk("R11 read count", 32'(rd_n), 32'd2);
    endtask

    task automatic t_scan_order();
        logic [31:0] a = 32'h0ABC_D123, s = 32'h0000_0F0F, t = 32'h0030_0000;
        logic [31:0] g = f_grp(a, s, t, 1'b0);
        logic [31:0] tg = f_tag(a, s, 1'b0);
        mem_clear();
        for (int k = 0; k < 5; k++) mem_put(g + 32'(8*k), tg ^ 32'(1 << k));
        mem_put(g + 40, tg);
        mem_put(g + 44, 32'h1111_1182);
        mem_put(g + 48, tg);
        mem_put(g + 52, 32'h2222_2182);
        walk(a, s, t, 1'b0, 1'b0);
        chk("R4 first match wins", real_addr, 32'h1111_1123);
        chk("R4 reads stop at match", 32'(rd_n), 32'd7);
        chk("R4 entry 5 tag addr", rd_log[rd_base + 5], g + 40);
        chk("R4 second word addr", rd_log[rd_base + 6], g + 44);
        chk("R3 near-miss ignored", 32'(status), 32'd1);
        chk("R7 ref set, no write", 32'(wr_n), 32'd0);
    endtask

    task automatic t_alt_hit_write();
        logic [31:0] a = 32'h0765_4321, s = 32'h0055_AA11, t = 32'h0050_0000;
        logic [31:0] gp = f_grp(a, s, t, 1'b0);
        logic [31:0] ga = f_grp(a, s, t, 1'b1);
        mem_clear();
        mem_put(gp + 24, f_tag(a, s, 1'b1));
        mem_put(gp + 28, 32'h5555_5002);
        mem_put(ga + 16, f_tag(a, s, 1'b1));
        mem_put(ga + 20, 32'hABCD_E002);
        walk(a, s, t, 1'b0, 1'b1);
        chk("R2 alternate group address", rd_log[rd_base + 8], ga);
        chk("R3 alternate tag matched", 32'(status), 32'd1);
        chk("R2 read count", 32'(rd_n), 32'd12);
        chk("R5 real from alternate", real_addr, 32'hABCD_E321);
        chk("R6 write allowed", 32'(may_write), 32'd1);
        chk("R8 two writes", 32'(wr_n), 32'd2);
        chk("R8 chg lane second", 32'(wr_log_b[wr_base + 1]), 32'h1);
        chk("R8 chg byte", 32'(wr_log_d[wr_base + 1][7:0]), 32'h82);
        chk("R8 memory word after", mem_get(ga + 20), 32'hABCD_E182);
    endtask

    task automatic t_no_entry();
        logic [31:0] a = 32'h0111_2222, s = 32'h0000_0777, t = 32'h0060_0000;
        mem_clear();
        walk(a, s, t, 1'b0, 1'b0);
        chk("R9 no entry status", 32'(status), 32'd2);
        chk("R9 sixteen reads", 32'(rd_n), 32'd16);
        chk("R2 last alt read", rd_log[rd_base + 15], f_grp(a, s, t, 1'b1) + 56);
        chk("R9 no writes", 32'(wr_n), 32'd0);
    endtask

    task automatic t_keys();
        logic [31:0] a = 32'h0222_3333, t = 32'h0070_0000;
        logic [31:0] s = 32'h2000_0444;
        logic [31:0] g = f_grp(a, s, t, 1'b0);
        mem_clear();
        mem_put(g, f_tag(a, s, 1'b0));
        mem_put(g + 4, 32'h3333_3000);
        walk(a, s, t, 1'b1, 1'b0);
        chk("R6 key user pp0 no read", 32'(may_read), 32'd0);
        chk("R9 prot status", 32'(status), 32'd3);
        chk("R7 no ref when unreadable", 32'(wr_n), 32'd0);
        walk(a, s, t, 1'b0, 1'b1);
        chk("R6 supervisor ignores user key", 32'(status), 32'd1);
        chk("R6 supervisor pp0 write", 32'(may_write), 32'd1);
        mem_clear();
        mem_put(g, f_tag(a, s, 1'b0));
        mem_put(g + 4, 32'h3333_3181);
        walk(a, s, t, 1'b1, 1'b0);
        chk("R6 key pp1 read", 32'(may_read), 32'd1);
        chk("R6 key pp1 no write", 32'(may_write), 32'd0);
    endtask

    task automatic t_read_only_store();
        logic [31:0] a = 32'h0333_4444, s = 32'h0000_0999, t = 32'h0080_0000;
        logic [31:0] g = f_grp(a, s, t, 1'b0);
        mem_clear();
        mem_put(g, f_tag(a, s, 1'b0));
        mem_put(g + 4, 32'h4444_4003);
        walk(a, s, t, 1'b0, 1'b1);
        chk("R9 store to read-only", 32'(status), 32'd3);
        chk("R7 ref still written", 32'(wr_n), 32'd1);
        chk("R8 no chg lane", 32'(wr_log_b[wr_base]), 32'h2);
        chk("R8 memory word after", mem_get(g + 4), 32'h4444_4103);
    endtask

    task automatic t_size_mask();
        logic [31:0] a = 32'h0FED_C000, s = 32'h00AB_CDEF, t = 32'h0400_01FF;
        logic [31:0] g = f_grp(a, s, t, 1'b0);
        mem_clear();
        mem_put(g + 56, f_tag(a, s, 1'b0));
        mem_put(g + 60, 32'h9000_0182);
        walk(a, s, t, 1'b0, 1'b1);
        chk("R1 masked high hash bits", rd_log[rd_base], g);
        chk("R4 last entry hit", real_addr, 32'h9000_0000);
        chk("R8 chg already set", 32'(wr_n), 32'd0);
    endtask

    task automatic t_busy_start();
        logic [31:0] a = 32'h0345_6789, s = 32'h0000_1234, t = 32'h0012_0000;
        logic [31:0] g = f_grp(a, s, t, 1'b0);
        int n, extra;
        mem_clear();
        mem_put(g + 8, f_tag(a, s, 1'b0));
        mem_put(g + 12, 32'h7777_7180);
        @(negedge clk);
        rd_base = rd_cnt;
        ea_i = a; seg_i = s; tbl_i = t; user_i = 1'b0; wr_i = 1'b0;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        ea_i = 32'h0F00_0ABC; start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        chk("R10 busy start ignored", real_addr, 32'h7777_7789);
        extra = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (done || mem_req) extra++;
        end
        chk("R10 no second walk", 32'(extra), 32'd0);
    endtask

    task automatic t_stall();
        stall_mode = 1'b1;
        t_alt_hit_write();
        stall_mode = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_primary_hit();
        t_scan_order();
        t_alt_hit_write();
        t_no_entry();
        t_keys();
        t_read_only_store();
        t_size_mask();
        t_busy_start();
        t_stall();
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule